// File: doc/BRIEF.md
# Hypercube Dimension-Ordered Router

This block is the routing stage of one node in a binary hypercube of `HC_DIM` dimensions (3 by default, so eight nodes). It has `HC_DIM + 1` input ports and the same number of output ports. Port k, for k below `HC_DIM`, is the link to the neighbour whose address differs from this node only in bit k. Port `HC_DIM` is the local port, used both to inject new messages and to deliver arrived ones. Each input port holds at most one message in a single slot. An occupied slot shows not-ready until its message leaves.

A message names a final destination node. It can also ask for a two-step route, in which it first travels to a pseudo-random intermediate node and then to its destination. Each hop picks the output link by fixed dimension precedence: the highest address bit in which the node and the current target differ is corrected first. This makes the number of hops equal to the number of differing bits, and it cannot deadlock. When several slots want the same output in one cycle, a round-robin arbiter for that output picks one. The others wait in their slots.

Top module: `hc_ecube_router`

## Requirements
- R1: After reset every input slot is empty (`in_ready` all ones) and no output is valid.
- R2: A message is encoded as {two_step (bit 2D), mid (bits 2D-1..D), dest (bits D-1..0)}. Its target is mid while two_step is 1 and dest otherwise. It leaves on the port equal to the highest bit position in which target and `node_id` differ. It leaves one clock after the edge that captured it, with all fields unchanged.
- R3: A message whose target equals `node_id` (with two_step 0) is delivered on the local port, index D.
- R4: A message with two_step 1 whose mid equals `node_id` has two_step cleared. It is then routed toward dest in the same cycle, with no extra latency.
- R5: On every accepted local injection the mid field is replaced by the intermediate-node generator state. The generator then advances once. It starts at 1 after reset, and each step shifts left with feedback bit s[D-1] xor s[D-2]; for D = 3 the sequence is 001, 010, 101, 011, 111, 110, 100.
- R6: In direct mode (two_step 0) the number of hops from any source to any destination equals the Hamming distance of the two addresses, and the message arrives at the destination's local port.
- R7: Slots contending for one output are served one per cycle, in round-robin order. The search starts at the input index after the last one granted on that output, and index 0 is searched first after reset.
- R8: A slot that loses arbitration keeps its message unchanged, with `in_ready` low. A new message offered to a full slot is ignored.
- R9: When two_step is 0, the mid field has no effect on routing and passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_id | input | HC_DIM | Address of this node |
| in_valid | input | HC_DIM+1 | Message offered on each input port |
| in_msg | input | (HC_DIM+1)*(2*HC_DIM+1) | Packed messages, port p at bits p*MW upward |
| in_ready | output | HC_DIM+1 | Input slot is empty |
| out_valid | output | HC_DIM+1 | Message leaving on each output port |
| out_msg | output | (HC_DIM+1)*(2*HC_DIM+1) | Packed outgoing messages |

## Verification
A message captured at a clock edge appears on its output port at the next edge, provided it wins arbitration. A message that loses waits one more edge per earlier winner. The bench drives each input at a falling edge, releases it at the next falling edge, and samples the outputs at the falling edge after that, so every result is compared two falling edges after it was offered. In the contention case the expected items are queued in grant order, one per later cycle. For the full-address sweep, the bench feeds each output back into the matching neighbour port of the next node. It waits an extra idle cycle before moving `node_id`, and counts the hops to the local port.

// File: rtl/hc_pkg.sv
package hc_pkg;
    localparam int HC_DIM   = 3;
    localparam int HC_PORTS = HC_DIM + 1;
    localparam int HC_LOCAL = HC_DIM;
    localparam int HC_PW    = $clog2(HC_PORTS);

    typedef logic [HC_DIM-1:0] node_t;
    typedef logic [HC_PW-1:0]  port_t;

    typedef struct packed {
        logic  two_step;
        node_t mid;
        node_t dest;
    } msg_t;

    localparam int HC_MW = $bits(msg_t);

    // Port of the highest set bit, or the local port if none is set.
    function automatic port_t top_diff(node_t x);
        port_t r;
        r = port_t'(HC_LOCAL);
        for (int b = 0; b < HC_DIM; b++)
            if (x[b]) r = port_t'(b);
        return r;
    endfunction

    function automatic node_t lfsr_next(node_t s);
        return {s[HC_DIM-2:0], s[HC_DIM-1] ^ s[HC_DIM-2]};
    endfunction
endpackage

// File: rtl/hc_route.sv
module hc_route
    import hc_pkg::*;
(
    input  node_t node_id,
    input  msg_t  msg_in,
    output port_t sel,
    output msg_t  msg_out
);
    node_t tgt;

    always_comb begin
        msg_out = msg_in;
        if (msg_in.two_step && (msg_in.mid == node_id))
            msg_out.two_step = 1'b0;
        tgt = msg_out.two_step ? msg_out.mid : msg_out.dest;
        sel = top_diff(tgt ^ node_id);
    end
endmodule

// File: rtl/hc_rr_arb.sv
module hc_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int PW = $clog2(N);

    logic [PW-1:0] ptr_q, ptr_d;
    logic          found;

    always_comb begin
        gnt   = '0;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (!found && req[(int'(ptr_q) + k) % N]) begin
                gnt[(int'(ptr_q) + k) % N] = 1'b1;
                found = 1'b1;
            end
        end
    end

    always_comb begin
        ptr_d = ptr_q;
        for (int k = 0; k < N; k++)
            if (gnt[k]) ptr_d = (k == N - 1) ? '0 : PW'(k + 1);
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_d;
    end

    // R7: at most one winner, and only among requesters
    a_r7_one_winner: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));
    a_r7_winner_requested: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);
    a_r7_no_idle_with_req: assert property (@(posedge clk) disable iff (rst)
        (req != '0) |-> (gnt != '0));
endmodule

// File: rtl/hc_lfsr.sv
module hc_lfsr
    import hc_pkg::*;
#(
    parameter int SEED = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    output node_t state
);
    always_ff @(posedge clk) begin
        if (rst)      state <= node_t'(SEED);
        else if (adv) state <= lfsr_next(state);
    end

    // R5: the generator never locks up at zero
    a_r5_nonzero: assert property (@(posedge clk) disable iff (rst)
        state != '0);
endmodule

// File: rtl/hc_ecube_router.sv
module hc_ecube_router
    import hc_pkg::*;
#(
    parameter int LFSR_SEED = 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [HC_DIM-1:0]         node_id,
    input  logic [HC_PORTS-1:0]       in_valid,
    input  logic [HC_PORTS*HC_MW-1:0] in_msg,
    output logic [HC_PORTS-1:0]       in_ready,
    output logic [HC_PORTS-1:0]       out_valid,
    output logic [HC_PORTS*HC_MW-1:0] out_msg
);
    msg_t                slot_q [HC_PORTS];
    logic [HC_PORTS-1:0] occ_q;
    port_t               sel    [HC_PORTS];
    msg_t                fwd    [HC_PORTS];
    logic [HC_PORTS-1:0] req_v  [HC_PORTS];
    logic [HC_PORTS-1:0] gnt_v  [HC_PORTS];
    logic [HC_PORTS-1:0] taken;
    msg_t                pick   [HC_PORTS];
    logic [HC_PORTS-1:0] ov_q;
    msg_t                om_q   [HC_PORTS];
    node_t               mid_gen;
    logic                inject;

    assign in_ready = ~occ_q;
    assign inject   = in_valid[HC_LOCAL] && !occ_q[HC_LOCAL];

    hc_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .adv   (inject),
        .state (mid_gen)
    );

    // Per-input route decision
    for (genvar i = 0; i < HC_PORTS; i++) begin : g_in
        hc_route u_route (
            .node_id (node_id),
            .msg_in  (slot_q[i]),
            .sel     (sel[i]),
            .msg_out (fwd[i])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                occ_q[i]  <= 1'b0;
                slot_q[i] <= '0;
            end else if (taken[i]) begin
                occ_q[i]  <= 1'b0;
            end else if (in_valid[i] && !occ_q[i]) begin
                occ_q[i]  <= 1'b1;
                slot_q[i] <= in_msg[i*HC_MW +: HC_MW];
                if (i == HC_LOCAL) slot_q[i].mid <= mid_gen;
            end
        end

        // R8: a waiting message stays put and unchanged
        a_r8_hold: assert property (@(posedge clk) disable iff (rst)
            (occ_q[i] && !taken[i]) |=> (occ_q[i] && $stable(slot_q[i])));
    end

    // Per-output arbitration and output register
    for (genvar j = 0; j < HC_PORTS; j++) begin : g_out
        always_comb begin
            for (int i = 0; i < HC_PORTS; i++)
                req_v[j][i] = occ_q[i] && (sel[i] == port_t'(j));
        end

        hc_rr_arb #(.N(HC_PORTS)) u_arb (
            .clk (clk),
            .rst (rst),
            .req (req_v[j]),
            .gnt (gnt_v[j])
        );

        always_comb begin
            pick[j] = '0;
            for (int i = 0; i < HC_PORTS; i++)
                if (gnt_v[j][i]) pick[j] = fwd[i];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                ov_q[j] <= 1'b0;
                om_q[j] <= '0;
            end else begin
                ov_q[j] <= |gnt_v[j];
                om_q[j] <= pick[j];
            end
        end

        assign out_msg[j*HC_MW +: HC_MW] = om_q[j];
    end

    assign out_valid = ov_q;

    always_comb begin
        taken = '0;
        for (int j = 0; j < HC_PORTS; j++)
            taken = taken | gnt_v[j];
    end

    // R2: a message on link k corrects exactly bit k, the highest differing bit
    for (genvar k = 0; k < HC_DIM; k++) begin : g_chk
        node_t tgt_k;
        assign tgt_k = om_q[k].two_step ? om_q[k].mid : om_q[k].dest;
        a_r2_top_bit: assert property (@(posedge clk) disable iff (rst)
            ov_q[k] |-> (((tgt_k ^ node_id) >> k) == node_t'(1)));
    end

    // R3: local delivery only at the final destination
    a_r3_local_arrived: assert property (@(posedge clk) disable iff (rst)
        ov_q[HC_LOCAL] |-> (!om_q[HC_LOCAL].two_step && om_q[HC_LOCAL].dest == node_id));
endmodule

// File: tb/tb_hc_ecube_router.sv
`timescale 1ns/1ps
module tb_hc_ecube_router;
    import hc_pkg::*;

    logic                      clk = 1'b0;
    logic                      rst = 1'b1;
    logic [HC_DIM-1:0]         node_id = '0;
    logic [HC_PORTS-1:0]       in_valid = '0;
    logic [HC_PORTS*HC_MW-1:0] in_msg = '0;
    logic [HC_PORTS-1:0]       in_ready;
    logic [HC_PORTS-1:0]       out_valid;
    logic [HC_PORTS*HC_MW-1:0] out_msg;

    always #2 clk = ~clk;

    hc_ecube_router dut (
        .clk(clk), .rst(rst), .node_id(node_id),
        .in_valid(in_valid), .in_msg(in_msg), .in_ready(in_ready),
        .out_valid(out_valid), .out_msg(out_msg)
    );

    int n_chk = 0;
    int n_bad = 0;
    node_t gen_m = node_t'(1);   // model of the intermediate-node generator

    typedef struct { int port; msg_t m; } exp_t;
    exp_t sbq[$];
    bit   sb_on = 1'b0;

    function automatic msg_t mk(bit ts, int mid, int dest);
        msg_t r;
        r.two_step = ts; r.mid = node_t'(mid); r.dest = node_t'(dest);
        return r;
    endfunction

    function automatic msg_t out_at(int p);
        return out_msg[p*HC_MW +: HC_MW];
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Driver: offer one message and queue the expected result
    task automatic offer(int port, msg_t m, int exp_port, msg_t exp_m);
        exp_t e;
        e.port = exp_port; e.m = exp_m;
        sbq.push_back(e);
        in_valid[port] = 1'b1;
        in_msg[port*HC_MW +: HC_MW] = m;
    endtask

    // Monitor: compare each produced message against the queue
    always @(negedge clk) begin
        if (sb_on && !rst) begin
            for (int p = 0; p < HC_PORTS; p++) begin
                if (out_valid[p]) begin
                    if (sbq.size() == 0) begin
                        check(1'b0, "R8 unexpected output", p, -1);
                    end else begin
                        exp_t e;
                        e = sbq.pop_front();
                        check(p == e.port, "R2/R7 output port", p, e.port);
                        check(out_at(p) == e.m, "R2/R4/R5/R9 message", int'(out_at(p)), int'(e.m));
                    end
                end
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Walk a message through the cube one node at a time
    task automatic walk(node_t s, node_t d, bit ts, output int hops, output bit arrived, output node_t mid_used);
        node_t cur;
        int    port;
        msg_t  m;
        bit    done;
        cur = s; port = HC_LOCAL; m = mk(ts, 0, d);
        hops = 0; arrived = 1'b0; done = 1'b0;
        mid_used = gen_m;
        gen_m = lfsr_next(gen_m);
        for (int it = 0; it < 2*HC_DIM + 2 && !done; it++) begin
            @(negedge clk);
            node_id = cur;
            in_valid[port] = 1'b1;
            in_msg[port*HC_MW +: HC_MW] = m;
            @(negedge clk);
            in_valid = '0;
            @(negedge clk);
            done = 1'b1;
            for (int p = HC_PORTS - 1; p >= 0; p--) begin
                if (out_valid[p]) begin
                    m = out_at(p);
                    if (p == HC_LOCAL) begin
                        arrived = (cur == d) && !m.two_step && (m.dest == d);
                    end else begin
                        cur = cur ^ node_t'(1 << p);
                        port = p;
                        hops++;
                        done = 1'b0;
                    end
                end
            end
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int    hops;
        bit    arr;
        node_t mu;
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(in_ready == '1, "R1 in_ready", int'(in_ready), 15);
        check(out_valid == '0, "R1 out_valid", int'(out_valid), 0);

        sb_on = 1'b1;
        // R7/R8/R9: three neighbours contend for link 2 at node 000
        node_id = 3'b000;
        offer(0, mk(0, 1, 4), 2, mk(0, 1, 4));
        offer(1, mk(0, 2, 4), 2, mk(0, 2, 4));
        offer(2, mk(0, 3, 4), 2, mk(0, 3, 4));
        @(negedge clk);
        in_valid = '0;
        check(in_ready[2] == 1'b0, "R8 slot busy while waiting", in_ready[2], 0);
        // R8: offer to the full slot must be ignored
        in_valid[2] = 1'b1;
        in_msg[2*HC_MW +: HC_MW] = mk(0, 7, 4);
        @(negedge clk);
        in_valid = '0;
        check(in_ready[2] == 1'b0, "R8 loser held", in_ready[2], 0);
        idle(5);
        check(sbq.size() == 0, "R7 all contenders served", sbq.size(), 0);

        // R2: path 010 -> 110 -> 111, highest differing bit first
        node_id = 3'b010;
        offer(0, mk(0, 0, 7), 2, mk(0, 0, 7));
        @(negedge clk); in_valid = '0; idle(3);
        node_id = 3'b110;
        offer(2, mk(0, 0, 7), 0, mk(0, 0, 7));
        @(negedge clk); in_valid = '0; idle(3);
        // R3: at destination, deliver locally
        node_id = 3'b111;
        offer(0, mk(0, 0, 7), HC_LOCAL, mk(0, 0, 7));
        @(negedge clk); in_valid = '0; idle(3);
        // R4: intermediate reached, phase cleared, head for dest
        node_id = 3'b110;
        offer(1, mk(1, 6, 1), 2, mk(0, 6, 1));
        @(negedge clk); in_valid = '0; idle(3);
        // R4: intermediate not reached, still steering toward mid
        node_id = 3'b000;
        offer(0, mk(1, 5, 2), 2, mk(1, 5, 2));
        @(negedge clk); in_valid = '0; idle(3);
        // R9: mid ignored in direct mode
        offer(1, mk(0, 7, 1), 0, mk(0, 7, 1));
        @(negedge clk); in_valid = '0; idle(3);
        // R5: local injections take generator values 001 then 010
        offer(HC_LOCAL, mk(1, 0, 6), 0, mk(1, 1, 6));
        gen_m = lfsr_next(gen_m);
        @(negedge clk); in_valid = '0; idle(3);
        offer(HC_LOCAL, mk(1, 0, 6), 1, mk(1, 2, 6));
        gen_m = lfsr_next(gen_m);
        @(negedge clk); in_valid = '0; idle(3);
        check(sbq.size() == 0, "R2 scoreboard drained", sbq.size(), 0);
        sb_on = 1'b0;

        // R6: every source/destination pair in direct mode
        for (int s = 0; s < (1 << HC_DIM); s++) begin
            for (int d = 0; d < (1 << HC_DIM); d++) begin
                walk(node_t'(s), node_t'(d), 1'b0, hops, arr, mu);
                check(hops == $countones(s ^ d), "R6 hop count", hops, $countones(s ^ d));
                check(arr, "R6 arrival", arr, 1);
            end
        end

        // R4/R5: two-step routes via the generated intermediate node
        for (int s = 0; s < (1 << HC_DIM); s += 3) begin
            node_t dd;
            dd = ~node_t'(s);
            walk(node_t'(s), dd, 1'b1, hops, arr, mu);
            check(hops == $countones(node_t'(s) ^ mu) + $countones(mu ^ dd),
                  "R4 two-step hops", hops, $countones(node_t'(s) ^ mu) + $countones(mu ^ dd));
            check(arr, "R4 two-step arrival", arr, 1);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule